// File: doc/BRIEF.md
# Receive Pause Frame Classifier and Filter

This block sits on the receive side of an Ethernet MAC and watches each incoming frame as a byte stream. It recognises flow-control pause frames, decides at the end of every frame whether the frame travels on to the host path or is dropped, and, when acting on pause frames is enabled, loads a transmit-inhibit counter with the frame's pause time. The counter is measured in pause quanta of 512 bit times. It counts down on a quantum strobe supplied by the transmit side, or on a divided version of that strobe. Transmission stays held off while the count is nonzero.

Two configuration inputs govern the block. One enables flow-control processing. The other chooses whether recognised pause frames are also handed to the host, which is useful when sniffing or debugging. The recommended setting for the host-forwarding control is off. Frames that are not pause frames always receive a forward decision. Address filtering and DMA are handled elsewhere.

Top module: `rx_pause_filter`

## Requirements
- R1: After reset, `frm_done`, `pause_load` and `tx_inhibit` are all 0.
- R2: A frame whose bytes 12 and 13 are 0x88, 0x08 and whose bytes 14 and 15 are 0x00, 0x01 (byte 0 marked by `rx_sof`), with at least 18 bytes, is a pause frame. For every frame, `frm_done` is 1 for exactly one cycle, in the cycle after the clock edge that samples the byte flagged with `rx_eof`.
- R3: A frame with another type value, another opcode, or fewer than 18 bytes gets `frm_fwd` = 1 and never produces `pause_load`.
- R4: With flow control enabled (`cfg_fc_en` = 1) and host forwarding off (`cfg_keep_pause` = 0), a pause frame gets `frm_fwd` = 0.
- R5: With `cfg_fc_en` = 1 and `cfg_keep_pause` = 1, a pause frame gets `frm_fwd` = 1.
- R6: With `cfg_fc_en` = 0, a pause frame gets `frm_fwd` = 0 whatever `cfg_keep_pause` is. It causes no `pause_load`, and `tx_inhibit` is unaffected by it.
- R7: A pause frame that ends with `rx_good` = 1 while `cfg_fc_en` = 1 raises `pause_load` together with `frm_done`. At the next edge the counter takes the big-endian value of bytes 16 and 17, so `tx_inhibit` is 1 from then on if that value is nonzero.
- R8: A pause frame that ends with `rx_good` = 0 causes no `pause_load` and leaves `tx_inhibit` unchanged. Its forward decision still follows R4 to R6.
- R9: The counter drops by one on each quantum tick and otherwise holds its value. `tx_inhibit` falls on the edge that takes the counter from 1 to 0, after exactly N ticks for a load of N.
- R10: A new load replaces whatever count remains. A load of zero clears `tx_inhibit` at the next edge.
- R11: When a load and a quantum tick fall in the same cycle, the load wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fc_en | input | 1 | Act on received pause frames |
| cfg_keep_pause | input | 1 | Forward pause frames to the host path |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of the frame |
| rx_eof | input | 1 | Last byte of the frame |
| rx_good | input | 1 | Frame passed its checks; meaningful with `rx_eof` |
| rx_data | input | 8 | Receive byte |
| frm_done | output | 1 | End-of-frame decision strobe |
| frm_fwd | output | 1 | 1 = forward the frame, 0 = drop; valid with `frm_done` |
| pause_load | output | 1 | Inhibit counter is being loaded this cycle |
| tx_inhibit | output | 1 | Hold off local transmission |

## Verification
The counter assertions assume the tick and load inputs can arrive in any combination, including together. They also assume that after reset the counter only changes through those two inputs, so the stimulus drives ticks on their own and, once, in the same cycle as a load. The decision assertion assumes every frame is framed correctly: one `rx_sof` byte first, one `rx_eof` byte last, and `rx_valid` held high in between. The bench therefore sends whole frames back to back, with no idle byte inside a frame. It keeps the configuration inputs steady during each decision cycle and applies every timing check to a counter model kept in the bench.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
   localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
   localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
   localparam int          HDR_FIRST     = 12;
   localparam int          HDR_LAST      = 17;

   typedef struct packed {
      logic [15:0] etype;
      logic [15:0] opcode;
      logic [15:0] ptime;
   } pause_hdr_t;
endpackage

// File: rtl/rpf_parser.sv
module rpf_parser
   import rpf_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             rx_good,
   input  logic [7:0]       rx_data,
   output pause_hdr_t       hdr,
   output logic             end_q,
   output logic             good_q,
   output logic             long_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] I_ET_H  = CNT_W'(HDR_FIRST);
   localparam logic [CNT_W-1:0] I_ET_L  = CNT_W'(HDR_FIRST + 1);
   localparam logic [CNT_W-1:0] I_OP_H  = CNT_W'(HDR_FIRST + 2);
   localparam logic [CNT_W-1:0] I_OP_L  = CNT_W'(HDR_FIRST + 3);
   localparam logic [CNT_W-1:0] I_PT_H  = CNT_W'(HDR_FIRST + 4);
   localparam logic [CNT_W-1:0] I_PT_L  = CNT_W'(HDR_LAST);

   if (CNT_W < 5) begin : g_bad_cnt_w
      $error("rpf_parser: CNT_W must reach byte index %0d", HDR_LAST);
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] idx;

   // index of the byte on the bus this cycle
   assign idx = rx_sof ? '0 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         hdr    <= '0;
         end_q  <= 1'b0;
         good_q <= 1'b0;
         long_q <= 1'b0;
      end else begin
         end_q <= rx_valid & rx_eof;
         if (rx_valid) begin
            cnt <= (idx == CNT_MAX) ? idx : idx + 1'b1;
            if (idx == I_ET_H) hdr.etype[15:8]  <= rx_data;
            if (idx == I_ET_L) hdr.etype[7:0]   <= rx_data;
            if (idx == I_OP_H) hdr.opcode[15:8] <= rx_data;
            if (idx == I_OP_L) hdr.opcode[7:0]  <= rx_data;
            if (idx == I_PT_H) hdr.ptime[15:8]  <= rx_data;
            if (idx == I_PT_L) hdr.ptime[7:0]   <= rx_data;
            if (rx_eof) begin
               good_q <= rx_good;
               long_q <= (idx >= I_PT_L);
            end
         end
      end
   end
endmodule

// File: rtl/rpf_classify.sv
module rpf_classify
   import rpf_pkg::*;
(
   input  pause_hdr_t hdr,
   input  logic       end_q,
   input  logic       good_q,
   input  logic       long_q,
   input  logic       cfg_fc_en,
   input  logic       cfg_keep_pause,
   output logic       fwd,
   output logic       act
);
   logic is_pause;

   always_comb begin
      is_pause = long_q && (hdr.etype == MAC_CTRL_TYPE) && (hdr.opcode == PAUSE_OPCODE);
      // pause frames pass only when both processing and keeping are on
      fwd      = !is_pause || (cfg_fc_en && cfg_keep_pause);
      act      = end_q && is_pause && good_q && cfg_fc_en;
   end
endmodule

// File: rtl/rpf_inhibit_timer.sv
module rpf_inhibit_timer #(
   parameter int TIME_W   = 16,
   parameter int TICK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              quanta_tick,
   input  logic              load_en,
   input  logic [TIME_W-1:0] load_val,
   output logic              inhibit
);
   localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TIME_W < 16) begin : g_bad_time_w
      $error("rpf_inhibit_timer: TIME_W must hold a 16-bit pause time");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("rpf_inhibit_timer: TICK_DIV must be at least 1");
   end

   logic              tick;
   logic [TIME_W-1:0] cnt;

   if (TICK_DIV == 1) begin : g_tick_direct
      assign tick = quanta_tick;
   end else begin : g_tick_divided
      logic [DIV_W-1:0] pre;
      always_ff @(posedge clk) begin
         if (!rst_n) pre <= '0;
         else if (quanta_tick) pre <= (pre == DIV_W'(TICK_DIV - 1)) ? '0 : pre + 1'b1;
      end
      assign tick = quanta_tick && (pre == DIV_W'(TICK_DIV - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (load_en)             cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign inhibit = (cnt != '0);

   p_load_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && load_val != '0 |=> inhibit && cnt == $past(load_val));
   p_zero_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && load_val == '0 |=> !inhibit);
   p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en && tick && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en && !tick |=> $stable(cnt));
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && tick |=> cnt == $past(load_val));
endmodule

// File: rtl/rx_pause_filter.sv
module rx_pause_filter
   import rpf_pkg::*;
#(
   parameter int CNT_W    = 11,
   parameter int TIME_W   = 16,
   parameter int TICK_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_fc_en,
   input  logic       cfg_keep_pause,
   input  logic       quanta_tick,
   input  logic       rx_valid,
   input  logic       rx_sof,
   input  logic       rx_eof,
   input  logic       rx_good,
   input  logic [7:0] rx_data,
   output logic       frm_done,
   output logic       frm_fwd,
   output logic       pause_load,
   output logic       tx_inhibit
);
   pause_hdr_t hdr;
   logic       end_q;
   logic       good_q;
   logic       long_q;

   rpf_parser #(.CNT_W(CNT_W)) u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_sof   (rx_sof),
      .rx_eof   (rx_eof),
      .rx_good  (rx_good),
      .rx_data  (rx_data),
      .hdr      (hdr),
      .end_q    (end_q),
      .good_q   (good_q),
      .long_q   (long_q)
   );

   rpf_classify u_classify (
      .hdr            (hdr),
      .end_q          (end_q),
      .good_q         (good_q),
      .long_q         (long_q),
      .cfg_fc_en      (cfg_fc_en),
      .cfg_keep_pause (cfg_keep_pause),
      .fwd            (frm_fwd),
      .act            (pause_load)
   );

   rpf_inhibit_timer #(.TIME_W(TIME_W), .TICK_DIV(TICK_DIV)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .quanta_tick (quanta_tick),
      .load_en     (pause_load),
      .load_val    (TIME_W'(hdr.ptime)),
      .inhibit     (tx_inhibit)
   );

   assign frm_done = end_q;

   // the classifier may only load the counter in a decision cycle from the parser
   p_load_in_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pause_load |-> frm_done);
endmodule

// File: tb/test_rx_pause_filter.sv
`timescale 1ns/1ps
module test_rx_pause_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_fc_en = 1'b0;
   logic       cfg_keep_pause = 1'b0;
   logic       quanta_tick = 1'b0;
   logic       rx_valid = 1'b0;
   logic       rx_sof = 1'b0;
   logic       rx_eof = 1'b0;
   logic       rx_good = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       frm_done;
   logic       frm_fwd;
   logic       pause_load;
   logic       tx_inhibit;

   int checks = 0;
   int errors = 0;
   int model  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rx_pause_filter i_rx_pause_filter (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_fc_en      (cfg_fc_en),
      .cfg_keep_pause (cfg_keep_pause),
      .quanta_tick    (quanta_tick),
      .rx_valid       (rx_valid),
      .rx_sof         (rx_sof),
      .rx_eof         (rx_eof),
      .rx_good        (rx_good),
      .rx_data        (rx_data),
      .frm_done       (frm_done),
      .frm_fwd        (frm_fwd),
      .pause_load     (pause_load),
      .tx_inhibit     (tx_inhibit)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_at(input int i, input logic [15:0] et,
                                          input logic [15:0] op, input logic [15:0] pt);
      case (i)
         12:      return et[15:8];
         13:      return et[7:0];
         14:      return op[15:8];
         15:      return op[7:0];
         16:      return pt[15:8];
         17:      return pt[7:0];
         default: return 8'(i * 7 + 3);
      endcase
   endfunction

   // sends one frame; returns decision seen in the frm_done cycle
   task automatic send_frame(input logic [15:0] et, input logic [15:0] op, input logic [15:0] pt,
                             input int len, input bit good, input bit tick_at_end,
                             output bit fwd, output bit ld);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_eof   = (i == len - 1);
         rx_good  = (i == len - 1) ? good : 1'b0;
         rx_data  = byte_at(i, et, op, pt);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
      check("R2", "frm_done pulse", frm_done, 1);
      fwd = frm_fwd;
      ld  = pause_load;
      quanta_tick = tick_at_end;
      @(negedge clk);
      quanta_tick = 1'b0;
      check("R2", "frm_done single cycle", frm_done, 0);
      if (ld) model = pt;
      else if (tick_at_end && model != 0) model--;
   endtask

   task automatic tick_once(input string req);
      @(negedge clk);
      quanta_tick = 1'b1;
      @(negedge clk);
      quanta_tick = 1'b0;
      if (model != 0) model--;
      check(req, "tx_inhibit after tick", tx_inhibit, int'(model != 0));
   endtask

   task automatic drain(input string req);
      while (model != 0) tick_once(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit fwd, ld;
      repeat (3) @(negedge clk);
      check("R1", "frm_done at reset", frm_done, 0);
      check("R1", "pause_load at reset", pause_load, 0);
      check("R1", "tx_inhibit at reset", tx_inhibit, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "tx_inhibit after reset", tx_inhibit, 0);

      // sweep: all configurations against every frame kind
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int kind = 0; kind < 6; kind++) begin
            logic [15:0] et, op, pt;
            int  len;
            bit  good, is_p, e_fwd, e_ld;
            string req;
            cfg_fc_en      = cfg[0];
            cfg_keep_pause = cfg[1];
            et = 16'h8808; op = 16'h0001; len = 64; good = 1'b1;
            pt = 16'(2 + kind);
            case (kind)
               1: len = 18;
               2: et = 16'h0800;
               3: op = 16'h0002;
               4: len = 17;
               5: good = 1'b0;
               default: ;
            endcase
            is_p  = (kind == 0) || (kind == 1) || (kind == 5);
            e_fwd = !is_p || (cfg[0] && cfg[1]);
            e_ld  = is_p && good && cfg[0];
            if (!is_p)       req = "R3";
            else if (!good)  req = "R8";
            else if (!cfg[0]) req = "R6";
            else if (cfg[1]) req = "R5";
            else             req = "R4";
            send_frame(et, op, pt, len, good, 1'b0, fwd, ld);
            check(req, "frm_fwd", fwd, e_fwd);
            check(req, "pause_load", ld, e_ld);
            check(e_ld ? "R7" : req, "tx_inhibit after frame", tx_inhibit, int'(model != 0));
            drain("R9");
         end
      end

      cfg_fc_en = 1'b1; cfg_keep_pause = 1'b0;

      // R9: hold without ticks, fall after exactly N ticks
      send_frame(16'h8808, 16'h0001, 16'd5, 64, 1'b1, 1'b0, fwd, ld);
      check("R7", "load pt=5", ld, 1);
      repeat (10) @(negedge clk);
      check("R9", "hold without tick", tx_inhibit, 1);
      for (int k = 0; k < 5; k++) tick_once("R9");
      check("R9", "released after 5 ticks", tx_inhibit, 0);

      // R10: reload replaces remaining count
      send_frame(16'h8808, 16'h0001, 16'd6, 64, 1'b1, 1'b0, fwd, ld);
      tick_once("R9");
      tick_once("R9");
      send_frame(16'h8808, 16'h0001, 16'd3, 64, 1'b1, 1'b0, fwd, ld);
      check("R10", "reload count", model, 3);
      tick_once("R10");
      tick_once("R10");
      check("R10", "still inhibited after 2 of 3", tx_inhibit, 1);
      tick_once("R10");
      check("R10", "released after reload count", tx_inhibit, 0);

      // R10: zero pause time releases at once
      send_frame(16'h8808, 16'h0001, 16'd9, 64, 1'b1, 1'b0, fwd, ld);
      check("R10", "inhibit before zero load", tx_inhibit, 1);
      send_frame(16'h8808, 16'h0001, 16'd0, 20, 1'b1, 1'b0, fwd, ld);
      check("R10", "zero load releases", tx_inhibit, 0);

      // R11: tick in the load cycle is lost
      send_frame(16'h8808, 16'h0001, 16'd3, 64, 1'b1, 1'b1, fwd, ld);
      check("R11", "load beat tick", model, 3);
      tick_once("R11");
      tick_once("R11");
      check("R11", "inhibit after 2 ticks", tx_inhibit, 1);
      tick_once("R11");
      check("R11", "released on third tick", tx_inhibit, 0);

      // R6: disabled processing leaves a running count alone
      send_frame(16'h8808, 16'h0001, 16'd4, 64, 1'b1, 1'b0, fwd, ld);
      cfg_fc_en = 1'b0; cfg_keep_pause = 1'b1;
      send_frame(16'h8808, 16'h0001, 16'd0, 64, 1'b1, 1'b0, fwd, ld);
      check("R6", "no load when disabled", ld, 0);
      check("R6", "dropped when disabled", fwd, 0);
      check("R6", "inhibit unchanged", tx_inhibit, 1);
      cfg_fc_en = 1'b1;
      drain("R9");
      check("R9", "final release", tx_inhibit, 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule